// File: doc/BRIEF.md
# Criticality-Predicting Warp Scheduler

This block chooses which warp of a streaming core issues next. For every warp it keeps a lag estimate: how far the warp trails its siblings. The estimate rises when a branch resolves onto a path that is expected to add dynamic instructions, and it rises again for every cycle the warp spends waiting on memory. It falls by one for each instruction the warp commits. Warps that lag the most are the ones that hold their thread block back, so they are given the issue slot first.

Selection is greedy. Once a warp holds the grant it keeps it for as long as it stays ready and active. When it stops being eligible, the most critical eligible warp takes over, and the lowest warp index wins a tie. The per-warp estimates are also driven out, so a cache replacement policy can use them.

Top module: `crit_warp_sched`

## Requirements
- R1: A pulse on `br_valid_i[w]` adds the 8-bit unsigned delta in slice w of `br_delta_i` (bits 8w+7..8w) to warp w's estimate. The new value shows on `crit_o` slice w (bits 16w+15..16w) after the next clock edge.
- R2: A pulse on `commit_i[w]` lowers warp w's estimate by one at the next clock edge.
- R3: Each cycle in which `stall_i[w]` is high adds one to warp w's estimate.
- R4: When the current holder is not eligible, the next `grant_o` is the one-hot code of the eligible warp with the highest estimate. A warp is eligible when it is active, ready and not being retired in that cycle.
- R5: A warp that holds the grant and stays eligible keeps the grant, even when another warp's estimate is higher.
- R6: Among eligible warps with equal estimates, the lowest index is granted.
- R7: An estimate saturates at 65535 when it rises and at 0 when it falls.
- R8: `grant_o` is registered. It is all zero in the cycle after one in which no warp was eligible, and it never has more than one bit set.
- R9: Events for several warps in one cycle are all applied. For a single warp, the branch and stall increments are applied before the commit decrement.
- R10: A pulse on `launch_i[w]` or `retire_i[w]` clears warp w's estimate. Launch makes the warp active and retire makes it inactive, with retire winning when both arrive together. An inactive warp is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| launch_i | input | 8 | Per-warp launch pulse |
| retire_i | input | 8 | Per-warp retire pulse |
| ready_i | input | 8 | Per-warp has-ready-instruction flag |
| br_valid_i | input | 8 | Per-warp branch resolution pulse |
| br_delta_i | input | 64 | Per-warp predicted extra instruction count, 8 bits each |
| commit_i | input | 8 | Per-warp instruction commit pulse |
| stall_i | input | 8 | Per-warp memory stall cycle flag |
| grant_o | output | 8 | One-hot issue grant, registered |
| crit_o | output | 128 | Per-warp criticality estimate, 16 bits each |

## Verification
The assertions assume that the inputs are known after reset, and that a retire pulse is not followed by branch, commit or stall events for that warp in the same cycle, which would otherwise change the estimate it clears. They also assume that at most one commit per warp arrives per cycle, since the port is one bit per warp. The stimulus uses single-cycle pulses and drives events only to launched warps, except where a case exercises a retired or inactive warp on purpose. It keeps each delta within 8 bits, so every expected estimate can be worked out by hand, including the path to saturation.

// File: rtl/crit_sched_pkg.sv
package crit_sched_pkg;
  localparam int unsigned DEF_N_WARPS = 8;
  localparam int unsigned DEF_CNT_W   = 16;
  localparam int unsigned DEF_DELTA_W = 8;
endpackage

// File: rtl/crit_counter.sv
module crit_counter #(
  parameter int unsigned CNT_W   = crit_sched_pkg::DEF_CNT_W,
  parameter int unsigned DELTA_W = crit_sched_pkg::DEF_DELTA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               br_i,
  input  logic [DELTA_W-1:0] delta_i,
  input  logic               stall_i,
  input  logic               commit_i,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam int unsigned SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] MAX_EXT = SUM_W'({CNT_W{1'b1}});

  logic [CNT_W-1:0] cnt_q, up_val, cnt_d;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(cnt_q) + (br_i ? SUM_W'(delta_i) : '0) + SUM_W'(stall_i);
    up_val = (sum > MAX_EXT) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    // increments first, then the commit decrement
    cnt_d = (commit_i && up_val != '0) ? up_val - 1'b1 : up_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/crit_picker.sv
module crit_picker #(
  parameter int unsigned N_WARPS = crit_sched_pkg::DEF_N_WARPS,
  parameter int unsigned CNT_W   = crit_sched_pkg::DEF_CNT_W
) (
  input  logic [N_WARPS-1:0]            elig_i,
  input  logic [N_WARPS-1:0][CNT_W-1:0] crit_i,
  output logic                          valid_o,
  output logic [N_WARPS-1:0]            pick_o
);
  always_comb begin
    logic [CNT_W-1:0] best;
    valid_o = 1'b0;
    pick_o  = '0;
    best    = '0;
    // strict compare keeps the lowest index on ties
    for (int i = 0; i < int'(N_WARPS); i++) begin
      if (elig_i[i] && (!valid_o || crit_i[i] > best)) begin
        valid_o = 1'b1;
        best    = crit_i[i];
        pick_o  = '0;
        pick_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/crit_warp_sched.sv
module crit_warp_sched #(
  parameter int unsigned N_WARPS = crit_sched_pkg::DEF_N_WARPS,
  parameter int unsigned CNT_W   = crit_sched_pkg::DEF_CNT_W,
  parameter int unsigned DELTA_W = crit_sched_pkg::DEF_DELTA_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_WARPS-1:0]         launch_i,
  input  logic [N_WARPS-1:0]         retire_i,
  input  logic [N_WARPS-1:0]         ready_i,
  input  logic [N_WARPS-1:0]         br_valid_i,
  input  logic [N_WARPS*DELTA_W-1:0] br_delta_i,
  input  logic [N_WARPS-1:0]         commit_i,
  input  logic [N_WARPS-1:0]         stall_i,
  output logic [N_WARPS-1:0]         grant_o,
  output logic [N_WARPS*CNT_W-1:0]   crit_o
);
  logic [N_WARPS-1:0]            active_q, grant_q, elig, pick, grant_d;
  logic [N_WARPS-1:0][CNT_W-1:0] crit;
  logic                          pick_valid, keep;

  for (genvar w = 0; w < int'(N_WARPS); w++) begin : g_warp
    crit_counter #(.CNT_W(CNT_W), .DELTA_W(DELTA_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (launch_i[w] | retire_i[w]),
      .br_i    (br_valid_i[w]),
      .delta_i (br_delta_i[w*DELTA_W +: DELTA_W]),
      .stall_i (stall_i[w]),
      .commit_i(commit_i[w]),
      .cnt_o   (crit[w])
    );
    assign crit_o[w*CNT_W +: CNT_W] = crit[w];
  end

  assign elig = active_q & ready_i & ~retire_i;

  crit_picker #(.N_WARPS(N_WARPS), .CNT_W(CNT_W)) u_pick (
    .elig_i (elig),
    .crit_i (crit),
    .valid_o(pick_valid),
    .pick_o (pick)
  );

  // greedy: holder keeps the slot while still eligible
  assign keep    = |(grant_q & elig);
  assign grant_d = keep ? grant_q : (pick_valid ? pick : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      grant_q  <= '0;
    end else begin
      active_q <= (active_q | launch_i) & ~retire_i;
      grant_q  <= grant_d;
    end
  end

  assign grant_o = grant_q;
endmodule

// File: rtl/crit_warp_sched_chk.sv
module crit_warp_sched_chk #(
  parameter int unsigned N_WARPS = 8,
  parameter int unsigned CNT_W   = 16
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic [N_WARPS-1:0]              ready_i,
  input logic [N_WARPS-1:0]              retire_i,
  input logic [N_WARPS-1:0]              launch_i,
  input logic [N_WARPS-1:0]              br_valid_i,
  input logic [N_WARPS-1:0]              commit_i,
  input logic [N_WARPS-1:0]              stall_i,
  input logic [N_WARPS-1:0]              active_q,
  input logic [N_WARPS-1:0]              grant_o,
  input logic [N_WARPS-1:0][CNT_W-1:0]   crit
);
  logic [N_WARPS-1:0] elig;
  assign elig = active_q & ready_i & ~retire_i;

  assert_grant_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  assert_grant_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig == '0) |=> (grant_o == '0));

  assert_grant_active_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o & ~active_q) == '0));

  assert_greedy_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((grant_o & elig) != '0) |=> $stable(grant_o));

  for (genvar w = 0; w < int'(N_WARPS); w++) begin : g_chk
    assert_commit_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_i[w] && !br_valid_i[w] && !stall_i[w] && !launch_i[w] && !retire_i[w]
       && crit[w] != '0) |=> (crit[w] == $past(crit[w]) - 1'b1));

    assert_sat_top_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (crit[w] == {CNT_W{1'b1}} && !commit_i[w] && !launch_i[w] && !retire_i[w])
      |=> (crit[w] == {CNT_W{1'b1}}));

    assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (launch_i[w] || retire_i[w]) |=> (crit[w] == '0));
  end
endmodule

bind crit_warp_sched crit_warp_sched_chk #(.N_WARPS(N_WARPS), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_i   (ready_i),
  .retire_i  (retire_i),
  .launch_i  (launch_i),
  .br_valid_i(br_valid_i),
  .commit_i  (commit_i),
  .stall_i   (stall_i),
  .active_q  (active_q),
  .grant_o   (grant_o),
  .crit      (crit)
);

// File: tb/sim_crit_warp_sched.sv
`timescale 1ns/1ps
module sim_crit_warp_sched;
  localparam int N = 8;
  localparam int CW = 16;
  localparam int DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  launch_i = '0, retire_i = '0, ready_i = '0;
  logic [N-1:0]  br_valid_i = '0, commit_i = '0, stall_i = '0;
  logic [N*DW-1:0] br_delta_i = '0;
  logic [N-1:0]  grant_o;
  logic [N*CW-1:0] crit_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  crit_warp_sched u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch_i), .retire_i(retire_i),
    .ready_i(ready_i), .br_valid_i(br_valid_i), .br_delta_i(br_delta_i),
    .commit_i(commit_i), .stall_i(stall_i), .grant_o(grant_o), .crit_o(crit_o)
  );

  function automatic int crit_of(int w);
    return int'(crit_o[w*CW +: CW]);
  endfunction

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic clr_events();
    launch_i = '0; retire_i = '0; br_valid_i = '0; commit_i = '0;
    stall_i = '0; br_delta_i = '0;
  endtask

  task automatic chk_crit(string req, int w, int exp);
    checks++;
    if (crit_of(w) !== exp) begin
      errors++;
      $display("FAIL %s warp %0d crit actual %0d expected %0d", req, w, crit_of(w), exp);
    end
  endtask

  task automatic chk_grant(string req, logic [N-1:0] exp);
    checks++;
    if (grant_o !== exp) begin
      errors++;
      $display("FAIL %s grant actual %b expected %b", req, grant_o, exp);
    end
  endtask

  task automatic br(int w, int d);
    br_valid_i[w] = 1'b1;
    br_delta_i[w*DW +: DW] = DW'(d);
  endtask

  task automatic t_reset();
    chk_grant("R8 reset", '0);
    for (int w = 0; w < N; w++) chk_crit("R10 reset", w, 0);
    launch_i = '1; tick(); clr_events();
    chk_grant("R8 launch", '0);
  endtask

  task automatic t_events();
    br(2, 40); br(5, 10); tick(); clr_events();
    chk_crit("R1", 2, 40);
    chk_crit("R1", 5, 10);
    for (int i = 0; i < 3; i++) begin commit_i[2] = 1'b1; tick(); end
    clr_events();
    chk_crit("R2", 2, 37);
    for (int i = 0; i < 5; i++) begin stall_i[5] = 1'b1; tick(); end
    clr_events();
    chk_crit("R3", 5, 15);
  endtask

  task automatic t_select();
    ready_i = 8'b0010_0100; tick();
    chk_grant("R4", 8'b0000_0100);
    br(5, 100); tick(); clr_events();
    chk_crit("R1", 5, 115);
    chk_grant("R5 hold", 8'b0000_0100);
    tick();
    chk_grant("R5 hold", 8'b0000_0100);
    ready_i = 8'b0010_0000; tick();
    chk_grant("R4 switch", 8'b0010_0000);
  endtask

  task automatic t_tie();
    ready_i = '0; tick();
    chk_grant("R8 idle", '0);
    ready_i = 8'b0000_1010; tick();
    chk_grant("R6 tie", 8'b0000_0010);
    ready_i = '0; tick();
  endtask

  task automatic t_sat();
    for (int i = 0; i < 260; i++) begin br(6, 255); tick(); end
    clr_events();
    chk_crit("R7 top", 6, 65535);
    br(6, 255); stall_i[6] = 1'b1; commit_i[6] = 1'b1; tick(); clr_events();
    chk_crit("R7 top commit", 6, 65534);
    commit_i[7] = 1'b1; tick(); clr_events();
    chk_crit("R7 bottom", 7, 0);
  endtask

  task automatic t_same_cycle();
    br(4, 5); commit_i[4] = 1'b1; br(0, 7); br(3, 9); commit_i[1] = 1'b1; tick(); clr_events();
    chk_crit("R9 order", 4, 4);
    chk_crit("R9 multi", 0, 7);
    chk_crit("R9 multi", 3, 9);
    chk_crit("R9 multi", 1, 0);
  endtask

  task automatic t_lifecycle();
    ready_i = 8'b0100_0000; retire_i[6] = 1'b1; tick(); clr_events();
    chk_crit("R10 retire", 6, 0);
    chk_grant("R10 retiring", '0);
    tick();
    chk_grant("R10 inactive", '0);
    launch_i[6] = 1'b1; tick(); clr_events();
    chk_grant("R10 launch cycle", '0);
    tick();
    chk_grant("R10 relaunched", 8'b0100_0000);
    ready_i = '0; br(3, 50); tick(); clr_events();
    launch_i[3] = 1'b1; tick(); clr_events();
    chk_crit("R10 launch clear", 3, 0);
    launch_i[0] = 1'b1; retire_i[0] = 1'b1; tick(); clr_events();
    ready_i = 8'b0000_0001; tick();
    chk_grant("R10 retire wins", '0);
    ready_i = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #23 rst_ni = 1'b1;
    tick();
    t_reset();
    t_events();
    t_select();
    t_tie();
    t_sat();
    t_same_cycle();
    t_lifecycle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule